// File: doc/BRIEF.md
# Smart Card Transmit Scheduler

This block drives the transmit side of an asynchronous smart card serial link. A host writes a byte. The block decides when the character frame may start. The frame may not begin until the previous character has fully left the line, including its standard guard period, and until an extra guard time set by the host has also run out. A byte written too early is parked in a one-entry holding register. It is launched on its own as soon as the line becomes free.

Each frame is built from bit slots of one elementary time unit (ETU) each, where an ETU is `ETU_CLKS` clock cycles. The slots are, in order: a low start bit, the eight data bits least significant first with a high level meaning one, an even parity bit, and two high guard slots. After these come `egt` extra ETUs with the line released. The line is open-drain, so the block only ever pulls it low or lets it float high. A synchronous-card mode bypasses all framing: the complement of bit 0 of each written byte becomes the pull-low request.

Top module: `sc_tx_sched`

## Requirements
- R1: After reset, `io_low`, `busy` and `tx_done` are all 0.
- R2: With `sync_mode` low, a write taken at an edge while no frame, extra guard time or pending byte is in progress starts a frame. The start bit (`io_low`=1) appears in the cycle that follows that edge.
- R3: A frame has twelve slots of `ETU_CLKS` cycles each. Slot 0 is the start bit with `io_low`=1. Slots 1 to 8 carry data bits 0 to 7, and `io_low` is the inverse of each bit. Slot 9 carries even parity, so `io_low` equals the XNOR of all data bits. Slots 10 and 11 are guard slots with `io_low`=0.
- R4: After slot 11, the line stays released for `egt` ETUs. The value of `egt` is sampled when slot 11 ends. A pending byte starts its frame one cycle after this extra time expires.
- R5: A write that arrives during a frame or during the extra guard time is held and is sent later, as R4 describes.
- R6: A write that arrives while a byte is already held is ignored. The held byte is the one that gets sent.
- R7: `busy` is 1 from the cycle after an accepted write until slot 11 of its frame ends. It is also 1 for as long as a byte is held.
- R8: `tx_done` is a single-cycle pulse. It appears in the first cycle after slot 11 of each frame ends.
- R9: With `sync_mode` high, each write makes `io_low` equal the inverse of `wr_data[0]` from the next cycle on. No frame is started, and `busy` stays 0.
- R10: With `egt` equal to 0, a held byte's start bit follows the end of the previous frame after exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| sync_mode | input | 1 | Selects synchronous-card pass-through |
| wr_en | input | 1 | Host write strobe, one cycle per byte |
| wr_data | input | 8 | Byte written by the host |
| egt | input | EGT_W | Extra guard time in ETUs |
| io_low | output | 1 | 1 pulls the card I/O line low, 0 releases it |
| busy | output | 1 | Frame in progress or byte held |
| tx_done | output | 1 | One-cycle pulse at the end of each frame |

## Verification
The assertions rely on two assumptions about the inputs. First, `sync_mode` changes only while the block is idle, so the framed machine and the pass-through path never share a frame. Second, `egt` is steady around the end of each frame. The stimulus respects both. It holds `egt` constant for the whole of each randomized transaction. It switches into and out of synchronous mode only after the line has been idle past the extra guard time. It places early writes only inside the frame or the extra guard window, never in the exact edge where a held byte launches.

// File: rtl/sc_tx_sched.sv
module sc_tx_sched #(
  parameter int ETU_CLKS = 372,
  parameter int EGT_W    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_mode,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  input  logic [EGT_W-1:0] egt,
  output logic             io_low,
  output logic             busy,
  output logic             tx_done
);
  localparam int CW = (ETU_CLKS > 1) ? $clog2(ETU_CLKS) : 1;
  localparam logic [CW-1:0] ETU_LAST = CW'(ETU_CLKS - 1);

  typedef enum logic [1:0] {IDLE, FRAME, XGRD} st_t;

  st_t              st;
  logic [3:0]       slot;
  logic [CW-1:0]    ecnt;
  logic [EGT_W-1:0] gcnt;
  logic [7:0]       shr, pend;
  logic             pend_v, par, sync_low, frame_low, idle_w;

  wire etu_end = (ecnt == ETU_LAST);
  wire take    = wr_en && !pend_v;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= IDLE;
      slot     <= '0;
      ecnt     <= '0;
      gcnt     <= '0;
      shr      <= '0;
      pend     <= '0;
      pend_v   <= 1'b0;
      par      <= 1'b0;
      sync_low <= 1'b0;
      tx_done  <= 1'b0;
    end else begin
      tx_done <= 1'b0;
      if (sync_mode) begin
        if (wr_en) sync_low <= ~wr_data[0];
      end else begin
        case (st)
          IDLE: if (wr_en || pend_v) begin
            shr    <= pend_v ? pend : wr_data;
            par    <= pend_v ? ^pend : ^wr_data;
            pend_v <= 1'b0;
            slot   <= '0;
            ecnt   <= '0;
            st     <= FRAME;
          end
          FRAME: begin
            if (take) begin
              pend   <= wr_data;
              pend_v <= 1'b1;
            end
            if (etu_end) begin
              ecnt <= '0;
              if (slot >= 4'd1 && slot <= 4'd8) shr <= shr >> 1;
              if (slot == 4'd11) begin
                tx_done <= 1'b1;
                gcnt    <= egt;
                st      <= (egt == '0) ? IDLE : XGRD;
              end else begin
                slot <= slot + 4'd1;
              end
            end else begin
              ecnt <= ecnt + 1'b1;
            end
          end
          XGRD: begin
            if (take) begin
              pend   <= wr_data;
              pend_v <= 1'b1;
            end
            if (etu_end) begin
              ecnt <= '0;
              gcnt <= gcnt - 1'b1;
              if (gcnt == EGT_W'(1)) st <= IDLE;
            end else begin
              ecnt <= ecnt + 1'b1;
            end
          end
          default: st <= IDLE;
        endcase
      end
    end
  end

  always_comb begin
    frame_low = 1'b0;
    if (st == FRAME) begin
      case (slot)
        4'd0:                                    frame_low = 1'b1;
        4'd1, 4'd2, 4'd3, 4'd4,
        4'd5, 4'd6, 4'd7, 4'd8:                  frame_low = ~shr[0];
        4'd9:                                    frame_low = ~par;
        default:                                 frame_low = 1'b0;
      endcase
    end
  end

  assign idle_w = (st == IDLE);
  assign io_low = sync_mode ? sync_low : frame_low;
  assign busy   = pend_v || (st == FRAME);
endmodule

// File: rtl/sc_tx_sched_chk.sv
module sc_tx_sched_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sync_mode,
  input logic       wr_en,
  input logic       wr_bit0,
  input logic       io_low,
  input logic       busy,
  input logic       tx_done,
  input logic       idle_w,
  input logic       pend_v,
  input logic [7:0] pend
);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R2
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sync_mode && idle_w) |=> (io_low && busy));

  // R4
  released_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sync_mode && !busy) |-> !io_low);

  // R6
  held_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v && !idle_w && !sync_mode) |=> $stable(pend));

  // R9
  sync_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && wr_en) |=> (io_low == !$past(wr_bit0)));

  // R9
  sync_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !busy) |=> !busy);

  // R7
  done_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(busy));
endmodule

bind sc_tx_sched sc_tx_sched_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .wr_en(wr_en),
  .wr_bit0(wr_data[0]), .io_low(io_low), .busy(busy), .tx_done(tx_done),
  .idle_w(idle_w), .pend_v(pend_v), .pend(pend)
);

// File: tb/sim_sc_tx_sched.sv
`timescale 1ns/1ps
module sim_sc_tx_sched;
  localparam int N = 4;
  localparam int EW = 8;

  logic clk = 0, rst_n = 0, sync_mode = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [EW-1:0] egt = 0;
  logic io_low, busy, tx_done;
  int checks = 0, errors = 0;

  logic [7:0] ba, bb, bc;
  bit have2;
  int wcyc, scyc, g;

  always #2.5 clk = ~clk;

  sc_tx_sched #(.ETU_CLKS(N), .EGT_W(EW)) u0 (
    .clk(clk), .rst_n(rst_n), .sync_mode(sync_mode), .wr_en(wr_en),
    .wr_data(wr_data), .egt(egt), .io_low(io_low), .busy(busy), .tx_done(tx_done));

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic fbit(input logic [7:0] d, input int s);
    if (s == 0) return 1'b1;
    if (s >= 1 && s <= 8) return ~d[s-1];
    if (s == 9) return ~(^d);
    return 1'b0;
  endfunction

  function automatic logic exp_io(input int m);
    if (m < 12*N) return fbit(ba, m / N);
    if (have2 && m >= scyc && m < scyc + 12*N) return fbit(bb, (m - scyc) / N);
    return 1'b0;
  endfunction

  function automatic logic exp_busy(input int m);
    if (m < 12*N) return 1'b1;
    return have2 && m >= wcyc + 1 && m < scyc + 12*N;
  endfunction

  function automatic logic exp_done(input int m);
    return (m == 12*N) || (have2 && m == scyc + 12*N);
  endfunction

  task automatic run_tx(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c,
                        input bit two, input int egt_v, input int w);
    int last;
    ba = a; bb = b; bc = c; have2 = two; g = egt_v; wcyc = w;
    scyc = (12 + g) * N + 1;
    last = two ? scyc + (12 + g) * N : (12 + g) * N;
    @(negedge clk);
    egt = EW'(g); wr_en = 1; wr_data = a;
    @(negedge clk);
    wr_en = 0;
    for (int m = 0; m <= last; m++) begin
      chk(io_low, exp_io(m), (m == 0) ? "R2 start bit" :
          (m < 12*N) ? "R3 frame bit" : (have2 && m >= scyc) ? "R5 held frame bit" : "R4 released line");
      chk(busy, exp_busy(m), "R7 busy");
      chk(tx_done, exp_done(m), "R8 tx_done");
      if (two && m == scyc) chk(io_low, 1'b1, (g == 0) ? "R10 back-to-back start" : "R4 start after guard");
      wr_en = 0;
      if (two && m == w)     begin wr_en = 1; wr_data = b; end
      if (two && m == w + 1) begin wr_en = 1; wr_data = c; end
      @(negedge clk);
    end
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(io_low, 1'b0, "R1 io_low reset");
    chk(busy, 1'b0, "R1 busy reset");
    chk(tx_done, 1'b0, "R1 tx_done reset");
    rst_n = 1;
    @(negedge clk);
    chk(io_low, 1'b0, "R1 io_low after reset");

    run_tx(8'h00, 8'hFF, 8'h5A, 1, 0, 0);
    run_tx(8'hFF, 8'h01, 8'h80, 1, 0, 12*N - 3);
    run_tx(8'hA5, 8'h3C, 8'hC3, 1, 3, (15)*N - 3);
    run_tx(8'h96, 8'h00, 8'h00, 0, 2, 0);

    for (int i = 0; i < 20; i++) begin
      int ge, wr;
      ge = $urandom_range(0, 5);
      wr = $urandom_range(0, (12 + ge) * N - 3);
      run_tx(8'($urandom), 8'($urandom), 8'($urandom), bit'($urandom_range(0, 1)), ge, wr);
    end

    @(negedge clk);
    sync_mode = 1;
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      wr_en = 1; wr_data = d;
      @(negedge clk);
      wr_en = 0;
      chk(io_low, ~d[0], "R9 sync copy");
      chk(busy, 1'b0, "R9 sync busy");
      @(negedge clk);
      chk(io_low, ~d[0], "R9 sync hold");
      chk(tx_done, 1'b0, "R9 sync no frame");
    end
    sync_mode = 0;
    @(negedge clk);
    chk(io_low, 1'b0, "R9 no frame after sync");
    chk(busy, 1'b0, "R9 nothing held after sync");
    repeat (4*N) @(negedge clk);
    chk(io_low, 1'b0, "R9 line stays released");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule